// File: doc/BRIEF.md
# Fetch-Stage Instruction Breakpoint Tagger

This block sits between instruction fetch and the decode latch. Each fetch presents a program counter and the instruction word read at that address. The block compares the program counter with a small table of programmable breakpoint addresses. It registers the word, the address and a 4-bit cause code into the decode latch one cycle later. When an enabled entry matches, the cause code marks a hardware breakpoint. Otherwise the code is zero. The block does not trap. Later stages carry the cause with the instruction and act on it when it reaches the memory stage.

Software loads the table through a single write port that carries an entry index, an address and an enable bit. A per-fetch skip input masks the comparison for that fetch only. This lets a debugger step over the breakpoint that has just fired without having to disable it. Comparison uses only the word-address bits, so the two low address bits are ignored on both the write port and the fetch side.

Top module: `fetch_bkpt_unit`

## Requirements
- R1: After synchronous reset, `dl_valid` is 0, `dl_cause` is 0, and every table entry is disabled. A fetch issued with no prior table writes therefore yields cause 0.
- R2: A fetch with `fe_valid`=1 in cycle t appears in cycle t+1 with `dl_pc` equal to `fe_pc` and `dl_word` equal to `fe_word`, whether or not a breakpoint matched.
- R3: When `fe_pc[31:2]` equals the stored address bits [31:2] of an enabled entry and `fe_skip`=0, `dl_cause` is 4'h9 (hardware breakpoint).
- R4: When no enabled entry matches, `dl_cause` is 4'h0 (none).
- R5: When `fe_skip`=1 for a fetch, `dl_cause` is 4'h0 even if an enabled entry matches.
- R6: An entry written with `tw_enable`=0 never matches, and such a write clears a previously enabled entry.
- R7: A table write in cycle t affects fetches from cycle t+1 onward. A fetch in cycle t itself compares against the contents from before the write.
- R8: When several enabled entries match the same address, the result is the single code 4'h9, with no priority among entries.
- R9: Address bits [1:0] are ignored on both `tw_addr` and `fe_pc` when comparing.
- R10: A cycle with `fe_valid`=0 gives `dl_valid`=0 and `dl_cause`=0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fe_valid | input | 1 | A fetch is presented this cycle |
| fe_pc | input | 32 | Program counter of the current fetch |
| fe_word | input | 32 | Instruction word read at `fe_pc` |
| fe_skip | input | 1 | Suppress breakpoint matching for this fetch |
| tw_en | input | 1 | Table write strobe |
| tw_idx | input | 2 | Entry index to write |
| tw_addr | input | 32 | Breakpoint address for the entry |
| tw_enable | input | 1 | Enable bit for the entry |
| dl_valid | output | 1 | Decode latch holds a fetched instruction |
| dl_pc | output | 32 | Address of the latched instruction |
| dl_word | output | 32 | Latched instruction word |
| dl_cause | output | 4 | Cause code: 0 none, 9 hardware breakpoint |

## Verification
The bench uses the default parameters: four entries and 32-bit address and data. With four entries, every slot can be written, cleared and loaded with a duplicate address, which makes multiple-match and clear-by-disable cases reachable. Directed cycles cover a write and a fetch in the same cycle, the skip mask, and low-bit aliasing. A random phase then draws addresses from a set of four, so hits, misses, skips and rewrites interleave often.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    localparam int CAUSE_W = 4;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE     = 4'h0,
        CAUSE_HW_BREAK = 4'h9
    } cause_e;

    // Word-address tag width for a byte address of the given width.
    function automatic int tag_width(input int addr_w);
        return addr_w - 2;
    endfunction

    // Reduce a hit vector and the skip mask to a cause code.
    function automatic cause_e cause_from_hits(input logic any_hit, input logic skip);
        return (any_hit && !skip) ? CAUSE_HW_BREAK : CAUSE_NONE;
    endfunction

endpackage

// File: rtl/bp_entry.sv
module bp_entry #(
    parameter int TAG_W = 30
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_sel,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_enable,
    input  logic [TAG_W-1:0] look_tag,
    output logic             hit
);

    logic             en_q;
    logic [TAG_W-1:0] tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            tag_q <= '0;
        end else if (wr_sel) begin
            en_q  <= wr_enable;
            tag_q <= wr_tag;
        end
    end

    assign hit = en_q && (tag_q == look_tag);

    // R7: a write loads the entry seen by the next cycle's lookup
    assert_write_lands_R7: assert property (@(posedge clk) disable iff (rst)
        wr_sel |=> (hit == ($past(wr_enable) && ($past(wr_tag) == look_tag))));

    // R6: an entry without its enable bit never hits
    assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && !wr_enable) |=> !hit);

endmodule

// File: rtl/bp_match_table.sv
module bp_match_table #(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       tw_en,
    input  logic [$clog2(ENTRIES)-1:0] tw_idx,
    input  logic [ADDR_W-1:0]          tw_addr,
    input  logic                       tw_enable,
    input  logic [ADDR_W-1:0]          look_pc,
    output logic                       any_hit
);

    localparam int TAG_W = bkpt_pkg::tag_width(ADDR_W);

    logic [ENTRIES-1:0] hit_vec;
    logic [TAG_W-1:0]   wr_tag;
    logic [TAG_W-1:0]   look_tag;

    assign wr_tag   = tw_addr[ADDR_W-1:2];
    assign look_tag = look_pc[ADDR_W-1:2];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        logic sel;
        assign sel = tw_en && (tw_idx == g[$clog2(ENTRIES)-1:0]);
        bp_entry #(.TAG_W(TAG_W)) u_entry (
            .clk      (clk),
            .rst      (rst),
            .wr_sel   (sel),
            .wr_tag   (wr_tag),
            .wr_enable(tw_enable),
            .look_tag (look_tag),
            .hit      (hit_vec[g])
        );
    end

    // R8: duplicates merge into one flag, no priority
    assign any_hit = |hit_vec;

    // R1: table comes out of reset empty
    assert_empty_after_reset_R1: assert property (@(posedge clk)
        rst |=> (hit_vec == '0));

endmodule

// File: rtl/bp_fetch_tag.sv
module bp_fetch_tag #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          fe_valid,
    input  logic [ADDR_W-1:0]             fe_pc,
    input  logic [DATA_W-1:0]             fe_word,
    input  logic                          fe_skip,
    input  logic                          any_hit,
    output logic                          dl_valid,
    output logic [ADDR_W-1:0]             dl_pc,
    output logic [DATA_W-1:0]             dl_word,
    output logic [bkpt_pkg::CAUSE_W-1:0]  dl_cause
);
    import bkpt_pkg::*;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] word;
        cause_e            cause;
    } latch_t;

    latch_t nxt, cur;

    always_comb begin
        nxt       = cur;
        nxt.valid = fe_valid;
        nxt.cause = CAUSE_NONE;
        if (fe_valid) begin
            nxt.pc    = fe_pc;
            nxt.word  = fe_word;
            nxt.cause = cause_from_hits(any_hit, fe_skip);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '{valid: 1'b0, pc: '0, word: '0, cause: CAUSE_NONE};
        end else begin
            cur <= nxt;
        end
    end

    assign dl_valid = cur.valid;
    assign dl_pc    = cur.pc;
    assign dl_word  = cur.word;
    assign dl_cause = cur.cause;

    assert_pass_through_R2: assert property (@(posedge clk) disable iff (rst)
        fe_valid |=> (dl_valid && dl_pc == $past(fe_pc) && dl_word == $past(fe_word)));

    assert_skip_masks_R5: assert property (@(posedge clk) disable iff (rst)
        (fe_valid && fe_skip) |=> (dl_cause == CAUSE_NONE));

    assert_idle_clean_R10: assert property (@(posedge clk) disable iff (rst)
        !fe_valid |=> (!dl_valid && dl_cause == CAUSE_NONE));

    // R3 / R4: only the two legal codes ever reach the latch
    assert_cause_legal_R3: assert property (@(posedge clk) disable iff (rst)
        (dl_cause == CAUSE_NONE) || (dl_cause == CAUSE_HW_BREAK));

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!dl_valid && dl_cause == CAUSE_NONE));

endmodule

// File: rtl/fetch_bkpt_unit.sv
module fetch_bkpt_unit #(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         fe_valid,
    input  logic [ADDR_W-1:0]            fe_pc,
    input  logic [DATA_W-1:0]            fe_word,
    input  logic                         fe_skip,
    input  logic                         tw_en,
    input  logic [$clog2(ENTRIES)-1:0]   tw_idx,
    input  logic [ADDR_W-1:0]            tw_addr,
    input  logic                         tw_enable,
    output logic                         dl_valid,
    output logic [ADDR_W-1:0]            dl_pc,
    output logic [DATA_W-1:0]            dl_word,
    output logic [bkpt_pkg::CAUSE_W-1:0] dl_cause
);

    logic any_hit;

    bp_match_table #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .tw_en    (tw_en),
        .tw_idx   (tw_idx),
        .tw_addr  (tw_addr),
        .tw_enable(tw_enable),
        .look_pc  (fe_pc),
        .any_hit  (any_hit)
    );

    bp_fetch_tag #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tag (
        .clk     (clk),
        .rst     (rst),
        .fe_valid(fe_valid),
        .fe_pc   (fe_pc),
        .fe_word (fe_word),
        .fe_skip (fe_skip),
        .any_hit (any_hit),
        .dl_valid(dl_valid),
        .dl_pc   (dl_pc),
        .dl_word (dl_word),
        .dl_cause(dl_cause)
    );

endmodule

// File: tb/fetch_bkpt_unit_bench.sv
`timescale 1ns/1ps
module fetch_bkpt_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fe_valid = 1'b0;
    logic [31:0] fe_pc = '0;
    logic [31:0] fe_word = '0;
    logic        fe_skip = 1'b0;
    logic        tw_en = 1'b0;
    logic [1:0]  tw_idx = '0;
    logic [31:0] tw_addr = '0;
    logic        tw_enable = 1'b0;
    logic        dl_valid;
    logic [31:0] dl_pc;
    logic [31:0] dl_word;
    logic [3:0]  dl_cause;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    fetch_bkpt_unit u_fetch_bkpt_unit (
        .clk(clk), .rst(rst),
        .fe_valid(fe_valid), .fe_pc(fe_pc), .fe_word(fe_word), .fe_skip(fe_skip),
        .tw_en(tw_en), .tw_idx(tw_idx), .tw_addr(tw_addr), .tw_enable(tw_enable),
        .dl_valid(dl_valid), .dl_pc(dl_pc), .dl_word(dl_word), .dl_cause(dl_cause)
    );

    typedef struct {
        bit          valid;
        logic [31:0] pc;
        logic [31:0] word;
        logic [3:0]  cause;
        string       req;
    } exp_t;

    exp_t        sb[$];
    logic [29:0] m_tag [4];
    bit          m_en  [4];

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got %h exp %h", req, what, got, exp);
        end
    endtask

    // Driver: one cycle of stimulus plus the predicted decode-latch contents.
    task automatic cyc(input bit fv, input logic [31:0] pc, input logic [31:0] w,
                       input bit sk, input bit we, input logic [1:0] idx,
                       input logic [31:0] wa, input bit wv, input string req);
        exp_t e;
        bit   hit;
        @(negedge clk);
        fe_valid = fv; fe_pc = pc; fe_word = w; fe_skip = sk;
        tw_en = we; tw_idx = idx; tw_addr = wa; tw_enable = wv;
        hit = 1'b0;
        for (int i = 0; i < 4; i++)
            if (m_en[i] && m_tag[i] == pc[31:2]) hit = 1'b1;
        e.valid = fv;
        e.pc    = pc;
        e.word  = w;
        e.cause = (fv && hit && !sk) ? 4'h9 : 4'h0;
        e.req   = req;
        sb.push_back(e);
        if (we) begin
            m_en[idx]  = wv;
            m_tag[idx] = wa[31:2];
        end
    endtask

    // Monitor: each result is sampled 2 ns after the edge that latched it.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                if (e.valid) begin
                    check("R2", "dl_valid", {31'b0, dl_valid}, 32'd1);
                    check("R2", "dl_pc", dl_pc, e.pc);
                    check("R2", "dl_word", dl_word, e.word);
                    check(e.req, "dl_cause", {28'b0, dl_cause}, {28'b0, e.cause});
                end else begin
                    check("R10", "dl_valid", {31'b0, dl_valid}, 32'd0);
                    check("R10", "dl_cause", {28'b0, dl_cause}, 32'd0);
                end
            end
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_en[i] = 1'b0; m_tag[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state of the latch
        check("R1", "dl_valid", {31'b0, dl_valid}, 32'd0);
        check("R1", "dl_cause", {28'b0, dl_cause}, 32'd0);
        cyc(1, 32'h0000_0000, 32'hAAAA_0001, 0, 0, 0, 0, 0, "R1");
        // R7: write and fetch in the same cycle sees the old table
        cyc(1, 32'h0000_0100, 32'hAAAA_0002, 0, 1, 2'd0, 32'h0000_0100, 1, "R7");
        cyc(1, 32'h0000_0100, 32'hAAAA_0003, 0, 0, 0, 0, 0, "R3");
        cyc(1, 32'h0000_0104, 32'hAAAA_0004, 0, 0, 0, 0, 0, "R4");
        // R9: low address bits ignored on both sides
        cyc(1, 32'h0000_0102, 32'hAAAA_0005, 0, 1, 2'd1, 32'h0000_0203, 1, "R9");
        cyc(1, 32'h0000_0200, 32'hAAAA_0006, 0, 0, 0, 0, 0, "R9");
        // R5: skip masks a real match
        cyc(1, 32'h0000_0100, 32'hAAAA_0007, 1, 0, 0, 0, 0, "R5");
        // R8: duplicate entries
        cyc(1, 32'h0000_0104, 32'hAAAA_0008, 0, 1, 2'd2, 32'h0000_0100, 1, "R4");
        cyc(1, 32'h0000_0100, 32'hAAAA_0009, 0, 0, 0, 0, 0, "R8");
        // R6: clearing entries
        cyc(1, 32'h0000_0100, 32'hAAAA_000A, 0, 1, 2'd0, 32'h0000_0100, 0, "R8");
        cyc(1, 32'h0000_0100, 32'hAAAA_000B, 0, 1, 2'd2, 32'h0000_0100, 0, "R6");
        cyc(1, 32'h0000_0100, 32'hAAAA_000C, 0, 1, 2'd3, 32'h0000_0300, 0, "R6");
        cyc(1, 32'h0000_0300, 32'hAAAA_000D, 0, 0, 0, 0, 0, "R6");
        // R10: no fetch
        cyc(0, 32'h0000_0200, 32'hAAAA_000E, 0, 0, 0, 0, 0, "R10");
        // Mixed traffic: hits, misses, skips, rewrites
        for (int n = 0; n < 400; n++) begin
            logic [31:0] pa, wa;
            pa = {22'b0, 2'($urandom_range(0, 3)) + 2'd1, 8'h00} | 32'($urandom_range(0, 3));
            wa = {22'b0, 2'($urandom_range(0, 3)) + 2'd1, 8'h00} | 32'($urandom_range(0, 3));
            cyc(($urandom_range(0, 7) != 0), pa, $urandom, ($urandom_range(0, 5) == 0),
                ($urandom_range(0, 3) == 0), 2'($urandom_range(0, 3)), wa,
                ($urandom_range(0, 3) != 0), "R3");
        end
        cyc(0, 0, 0, 0, 0, 0, 0, 0, "R10");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule